// File: doc/BRIEF.md
# ADC Result Window Comparator

This block sits beside an analog-to-digital converter and inspects every finished sample result as it leaves the converter's filtering stage. Each result arrives with a valid strobe, a channel number, a flag saying whether that channel's data is two's-complement, and a flag saying whether the result is a full 16-bit word (accumulated or left-justified) or a plain 12-bit value. The block reduces the result to 12 bits. It then tests the value against a programmable low limit and a programmable high limit, and evaluates five independent conditions on it. A one-cycle event pulse is raised when any enabled condition holds.

Software sets the block up through a small register port with three words. The first is the window word, which holds both limits, the five condition enables and a master compare enable. The second is a per-channel monitor mask. The third is a sticky status word that records which enabled conditions have fired. The window word and the mask are protected: while the parent converter is running, writes to them are discarded and answered with a bus error. The status word can always be cleared.

Top module: `adc_window_cmp`

## Requirements
- R1: Register address 0 is the window word: low limit in bits 11:0, master compare enable in bit 12, enables for "value below low limit" in bit 13, "value at or above low limit" in bit 14, "low limit ≤ value < high limit" in bit 15, high limit in bits 27:16, "value below high limit" in bit 28 and "value at or above high limit" in bit 29. All of these bits reset to zero. Bits 31:30 always read as zero. Reads are combinational while `reg_rd` is high, are allowed in any converter state, and return zero when `reg_rd` is low.
- R2: While `conv_enable` is high, a write to address 0 or address 1 leaves the stored value unchanged and makes `reg_err` high for exactly the following cycle. Any other write leaves `reg_err` low.
- R3: When `res_wide` is 1, data bits 15:4 form the compared value. Otherwise data bits 11:0 are used as they are.
- R4: When `res_signed` is 1, the value and both limits are compared as 12-bit two's-complement numbers. When it is 0, all three are compared as unsigned numbers.
- R5: The condition vector has bit 0 = value < low, bit 1 = low ≤ value, bit 2 = low ≤ value < high, bit 3 = value < high, and bit 4 = high ≤ value.
- R6: A result is evaluated only when `res_valid` is high, the master compare enable is set, and the mask bit selected by `res_chan` is set. Otherwise it causes no event and sets no status bit.
- R7: `cmp_event` is high for one cycle, in the cycle after an evaluated result, exactly when at least one condition that is both true and enabled exists for that result.
- R8: Address 2 holds five sticky status bits in the condition order of R5. A bit is set in the cycle after an evaluated result for which that condition is both true and enabled. Writing 1 to a bit clears it, in any converter state. A set in the same cycle as a clear takes priority.
- R9: Address 1 holds the channel monitor mask in bits 15:0, with bit k enabling channel k. It resets to zero. Writes to address 3 have no effect, and reads of address 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_enable | input | 1 | Parent converter enabled; protects registers 0 and 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 window, 1 mask, 2 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| reg_err | output | 1 | Bus error response, one cycle after a rejected write |
| res_valid | input | 1 | Result valid strobe |
| res_data | input | 16 | Result data |
| res_chan | input | 4 | Result channel index |
| res_signed | input | 1 | Result is two's-complement |
| res_wide | input | 1 | Result is a 16-bit word; compare its top 12 bits |
| cmp_event | output | 1 | Comparison event pulse |

## Verification
Two cases are hard to reach from the ports. The first is a status write-one-to-clear that lands on the same edge as a result which sets the same bit. The second is a protected write that meets a result stream already in flight. The bench forces the first case by issuing the clear and a matching result in one cycle. It covers the second with a long random phase that toggles `conv_enable`, mixes writes to every address with results, and compares every cycle against a behavioural model. Boundary values at exactly the low and high limits are driven in both unsigned and signed form. Among them is a signed window whose raw bit patterns would fall outside the window if read as unsigned.

// File: rtl/adc_wcmp_pkg.sv
package adc_wcmp_pkg;

    localparam int LIM_W    = 12;
    localparam int RES_W    = 16;
    localparam int CHAN_W   = 4;
    localparam int NUM_CHAN = 1 << CHAN_W;
    localparam int NUM_COND = 5;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 2;

    // condition indices (also status bit positions)
    localparam int C_LO_LT = 0;
    localparam int C_LO_GE = 1;
    localparam int C_WIN   = 2;
    localparam int C_HI_LT = 3;
    localparam int C_HI_GE = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_WIN  = 2'd0,
        RA_MASK = 2'd1,
        RA_STAT = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [1:0]       rsvd;
        logic             en_hi_ge;
        logic             en_hi_lt;
        logic [LIM_W-1:0] hi;
        logic             en_win;
        logic             en_lo_ge;
        logic             en_lo_lt;
        logic             cmp_on;
        logic [LIM_W-1:0] lo;
    } win_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [CHAN_W-1:0] chan;
        logic              is_signed;
        logic [LIM_W-1:0]  val;
    } sample_t;

    function automatic logic [LIM_W-1:0] take_top(input logic [RES_W-1:0] d,
                                                  input logic wide);
        return wide ? d[RES_W-1 -: LIM_W] : d[LIM_W-1:0];
    endfunction

    function automatic logic signed [LIM_W:0] to_cmp(input logic [LIM_W-1:0] x,
                                                    input logic sgn);
        return sgn ? $signed({x[LIM_W-1], x}) : $signed({1'b0, x});
    endfunction

    function automatic logic [NUM_COND-1:0] cond_enables(input win_cfg_t c);
        logic [NUM_COND-1:0] e;
        e = '0;
        e[C_LO_LT] = c.en_lo_lt;
        e[C_LO_GE] = c.en_lo_ge;
        e[C_WIN]   = c.en_win;
        e[C_HI_LT] = c.en_hi_lt;
        e[C_HI_GE] = c.en_hi_ge;
        return e;
    endfunction

endpackage

// File: rtl/adc_wcmp_front.sv
module adc_wcmp_front
    import adc_wcmp_pkg::*;
(
    input  logic              res_valid,
    input  logic [RES_W-1:0]  res_data,
    input  logic [CHAN_W-1:0] res_chan,
    input  logic              res_signed,
    input  logic              res_wide,
    output sample_t           smp
);
    always_comb begin
        smp.valid     = res_valid;
        smp.chan      = res_chan;
        smp.is_signed = res_signed;
        smp.val       = take_top(res_data, res_wide);
    end
endmodule

// File: rtl/adc_wcmp_eval.sv
module adc_wcmp_eval
    import adc_wcmp_pkg::*;
(
    input  sample_t             smp,
    input  win_cfg_t            cfg,
    output logic [NUM_COND-1:0] cond
);
    logic signed [LIM_W:0] v_s;
    logic signed [LIM_W:0] lo_s;
    logic signed [LIM_W:0] hi_s;
    logic                  below_lo;
    logic                  below_hi;

    always_comb begin
        v_s      = to_cmp(smp.val, smp.is_signed);
        lo_s     = to_cmp(cfg.lo,  smp.is_signed);
        hi_s     = to_cmp(cfg.hi,  smp.is_signed);
        below_lo = (v_s < lo_s);
        below_hi = (v_s < hi_s);
        cond          = '0;
        cond[C_LO_LT] = below_lo;
        cond[C_LO_GE] = !below_lo;
        cond[C_WIN]   = !below_lo && below_hi;
        cond[C_HI_LT] = below_hi;
        cond[C_HI_GE] = !below_hi;
    end
endmodule

// File: rtl/adc_wcmp_regs.sv
module adc_wcmp_regs
    import adc_wcmp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                conv_enable,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                reg_err,
    input  logic [NUM_COND-1:0] stat_set,
    output win_cfg_t            cfg_o,
    output logic [NUM_CHAN-1:0] mask_o
);
    reg_addr_e           addr;
    logic                prot_hit;
    logic                win_we;
    logic                mask_we;
    logic                stat_we;
    win_cfg_t            cfg_q;
    logic [NUM_CHAN-1:0] mask_q;
    logic [NUM_COND-1:0] stat_q;
    logic                err_q;

    always_comb begin
        addr     = reg_addr_e'(reg_addr);
        prot_hit = reg_wr && ((addr == RA_WIN) || (addr == RA_MASK));
        win_we   = reg_wr && !conv_enable && (addr == RA_WIN);
        mask_we  = reg_wr && !conv_enable && (addr == RA_MASK);
        stat_we  = reg_wr && (addr == RA_STAT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            mask_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (win_we) begin
                cfg_q      <= win_cfg_t'(reg_wdata);
                cfg_q.rsvd <= 2'b00;
            end
            if (mask_we)
                mask_q <= reg_wdata[NUM_CHAN-1:0];
            err_q <= prot_hit && conv_enable;
        end
    end

    for (genvar i = 0; i < NUM_COND; i++) begin : g_stat
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else if (stat_set[i])
                bit_q <= 1'b1;
            else if (stat_we && reg_wdata[i])
                bit_q <= 1'b0;
        end
        assign stat_q[i] = bit_q;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (addr)
                RA_WIN:  reg_rdata = cfg_q;
                RA_MASK: reg_rdata = WORD_W'(mask_q);
                RA_STAT: reg_rdata = WORD_W'(stat_q);
                default: reg_rdata = '0;
            endcase
        end
    end

    assign reg_err = err_q;
    assign cfg_o   = cfg_q;
    assign mask_o  = mask_q;
endmodule

// File: rtl/adc_window_cmp.sv
module adc_window_cmp
    import adc_wcmp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                conv_enable,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                reg_err,
    input  logic                res_valid,
    input  logic [RES_W-1:0]    res_data,
    input  logic [CHAN_W-1:0]   res_chan,
    input  logic                res_signed,
    input  logic                res_wide,
    output logic                cmp_event
);
    sample_t             smp_w;
    win_cfg_t            cfg_w;
    logic [NUM_CHAN-1:0] mask_w;
    logic [NUM_COND-1:0] cond_w;
    logic [NUM_COND-1:0] hits_w;
    logic                qualify;
    logic                event_q;

    adc_wcmp_front u_front (
        .res_valid  (res_valid),
        .res_data   (res_data),
        .res_chan   (res_chan),
        .res_signed (res_signed),
        .res_wide   (res_wide),
        .smp        (smp_w)
    );

    adc_wcmp_eval u_eval (
        .smp  (smp_w),
        .cfg  (cfg_w),
        .cond (cond_w)
    );

    adc_wcmp_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .conv_enable (conv_enable),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .reg_err     (reg_err),
        .stat_set    (hits_w),
        .cfg_o       (cfg_w),
        .mask_o      (mask_w)
    );

    always_comb begin
        qualify = smp_w.valid && cfg_w.cmp_on && mask_w[smp_w.chan];
        hits_w  = cond_w & cond_enables(cfg_w) & {NUM_COND{qualify}};
    end

    always_ff @(posedge clk) begin
        if (rst)
            event_q <= 1'b0;
        else
            event_q <= |hits_w;
    end

    assign cmp_event = event_q;
endmodule

// File: rtl/adc_wcmp_chk.sv
module adc_wcmp_chk
    import adc_wcmp_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                conv_enable,
    input logic                reg_wr,
    input logic                reg_rd,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [WORD_W-1:0]   reg_rdata,
    input logic                reg_err,
    input logic                res_valid,
    input logic                cmp_event,
    input win_cfg_t            cfg,
    input logic [NUM_COND-1:0] cond
);
    AST_PROT_ERR: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && conv_enable && (reg_addr < 2'd2)) |=> reg_err); // R2

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        reg_err |-> $past(reg_wr && conv_enable && (reg_addr < 2'd2))); // R2

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && conv_enable && (reg_addr == 2'd0)) |=> $stable(cfg)); // R2

    AST_EVT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        cmp_event |-> $past(res_valid && cfg.cmp_on)); // R6

    AST_WIN_INSIDE: assert property (@(posedge clk) disable iff (rst)
        cond[2] |-> (cond[1] && cond[3])); // R5

    AST_LO_SPLIT: assert property (@(posedge clk) disable iff (rst)
        $countones(cond[1:0]) == 1); // R5

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && (reg_addr == 2'd0)) |-> (reg_rdata[31:30] == 2'b00)); // R1
endmodule

bind adc_window_cmp adc_wcmp_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .conv_enable (conv_enable),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .reg_err     (reg_err),
    .res_valid   (res_valid),
    .cmp_event   (cmp_event),
    .cfg         (cfg_w),
    .cond        (cond_w)
);

// File: tb/adc_window_cmp_bench.sv
`timescale 1ns/1ps
module adc_window_cmp_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_enable = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_err;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic [3:0]  res_chan = '0;
    logic        res_signed = 1'b0;
    logic        res_wide = 1'b0;
    logic        cmp_event;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] m_cfg  = '0;
    logic [15:0] m_mask = '0;
    logic [4:0]  m_stat = '0;

    always #10 clk = ~clk;

    adc_window_cmp u_adc_window_cmp (
        .clk(clk), .rst(rst), .conv_enable(conv_enable),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
        .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
        .res_signed(res_signed), .res_wide(res_wide), .cmp_event(cmp_event)
    );

    function automatic int sval(input logic [11:0] t, input logic sg);
        if (sg && t[11]) return int'(t) - 4096;
        return int'(t);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one clock: model predicts, design steps, compare at the falling edge
    task automatic step(input string tag);
        logic [11:0] t;
        int v, lo, hi;
        logic [4:0] c, en, hits;
        logic q, e_evt, e_err;
        logic [31:0] n_cfg;
        logic [15:0] n_mask;
        logic [4:0]  n_stat;
        t  = res_wide ? res_data[15:4] : res_data[11:0];
        v  = sval(t, res_signed);
        lo = sval(m_cfg[11:0], res_signed);
        hi = sval(m_cfg[27:16], res_signed);
        c[0] = v < lo;
        c[1] = lo <= v;
        c[2] = (lo <= v) && (v < hi);
        c[3] = v < hi;
        c[4] = hi <= v;
        en = {m_cfg[29], m_cfg[28], m_cfg[15], m_cfg[14], m_cfg[13]};
        q  = res_valid && m_cfg[12] && m_mask[res_chan];
        hits  = q ? (c & en) : 5'b0;
        e_evt = |hits;
        e_err = reg_wr && conv_enable && (reg_addr < 2);
        n_cfg = m_cfg; n_mask = m_mask; n_stat = m_stat;
        if (reg_wr && !conv_enable && reg_addr == 0) n_cfg = reg_wdata & 32'h3FFF_FFFF;
        if (reg_wr && !conv_enable && reg_addr == 1) n_mask = reg_wdata[15:0];
        if (reg_wr && reg_addr == 2) n_stat = n_stat & ~reg_wdata[4:0];
        n_stat = n_stat | hits;
        @(posedge clk);
        @(negedge clk);
        m_cfg = n_cfg; m_mask = n_mask; m_stat = n_stat;
        check(tag, "cmp_event", 32'(cmp_event), 32'(e_evt));
        check("R2", "reg_err", 32'(reg_err), 32'(e_err));
        res_valid = 1'b0;
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        logic [31:0] e;
        reg_rd = 1'b1; reg_addr = a;
        #1;
        case (a)
            2'd0: e = m_cfg;
            2'd1: e = 32'(m_mask);
            2'd2: e = 32'(m_stat);
            default: e = '0;
        endcase
        check(tag, "reg_rdata", reg_rdata, e);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(tag);
    endtask

    task automatic smp(input logic [3:0] ch, input logic [15:0] d,
                       input logic sg, input logic wd, input string tag);
        res_valid = 1'b1; res_chan = ch; res_data = d;
        res_signed = sg; res_wide = wd;
        step(tag);
    endtask

    function automatic logic [31:0] mkcfg(input logic [11:0] lo, input logic [11:0] hi,
                                          input logic on, input logic [4:0] en);
        return {2'b00, en[4], en[3], hi, en[2], en[1], en[0], on, lo};
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state
        check("R7", "cmp_event after reset", 32'(cmp_event), 32'd0);
        rd(2'd0, "R1"); rd(2'd1, "R9"); rd(2'd2, "R8"); rd(2'd3, "R9");

        // configuration and read back, reserved bits
        wr(2'd0, 32'hC000_0000 | mkcfg(12'h100, 12'h300, 1'b1, 5'b11111), "R1");
        rd(2'd0, "R1");
        check("R1", "reserved bits", 32'(reg_rdata[31:30]), 32'd0);
        wr(2'd1, 32'hFFFF_0005, "R9");
        rd(2'd1, "R9");
        wr(2'd3, 32'hFFFF_FFFF, "R9");
        rd(2'd0, "R9"); rd(2'd1, "R9"); rd(2'd3, "R9");

        // unsigned narrow results around the limits
        smp(4'd0, 16'h00FF, 1'b0, 1'b0, "R5");
        smp(4'd0, 16'h0100, 1'b0, 1'b0, "R5");
        smp(4'd0, 16'h02FF, 1'b0, 1'b0, "R5");
        smp(4'd0, 16'h0300, 1'b0, 1'b0, "R5");
        smp(4'd0, 16'hFFFF, 1'b0, 1'b0, "R3");
        rd(2'd2, "R8");
        wr(2'd2, 32'h1F, "R8");
        rd(2'd2, "R8");

        // window only: boundary values
        wr(2'd0, mkcfg(12'h100, 12'h300, 1'b1, 5'b00100), "R5");
        smp(4'd2, 16'h0300, 1'b0, 1'b0, "R5");
        smp(4'd2, 16'h0100, 1'b0, 1'b0, "R5");
        smp(4'd2, 16'h00FF, 1'b0, 1'b0, "R5");
        rd(2'd2, "R8");

        // wide results use bits 15:4
        smp(4'd0, 16'h1000, 1'b0, 1'b1, "R3");
        smp(4'd0, 16'h0FFF, 1'b0, 1'b1, "R3");
        smp(4'd0, 16'h3000, 1'b0, 1'b1, "R3");

        // signed window -256..127
        wr(2'd0, mkcfg(12'hF00, 12'h080, 1'b1, 5'b00100), "R4");
        smp(4'd2, 16'h0F80, 1'b1, 1'b0, "R4");
        smp(4'd2, 16'h0F80, 1'b0, 1'b0, "R4");
        smp(4'd2, 16'h0080, 1'b1, 1'b0, "R4");
        smp(4'd2, 16'hEFF0, 1'b1, 1'b1, "R4");
        smp(4'd2, 16'hF000, 1'b1, 1'b1, "R4");

        // masking and master enable
        smp(4'd1, 16'h0F80, 1'b1, 1'b0, "R6");
        wr(2'd0, mkcfg(12'hF00, 12'h080, 1'b0, 5'b11111), "R6");
        smp(4'd0, 16'h0000, 1'b1, 1'b0, "R6");
        rd(2'd2, "R6");

        // clear colliding with a set of the same bit
        wr(2'd0, mkcfg(12'h100, 12'h300, 1'b1, 5'b00010), "R8");
        smp(4'd0, 16'h0200, 1'b0, 1'b0, "R8");
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h1F;
        smp(4'd0, 16'h0200, 1'b0, 1'b0, "R8");
        rd(2'd2, "R8");

        // protection while converter runs
        conv_enable = 1'b1;
        wr(2'd0, mkcfg(12'h055, 12'h0AA, 1'b1, 5'b11111), "R2");
        rd(2'd0, "R2");
        wr(2'd1, 32'h0000_FFFF, "R2");
        rd(2'd1, "R2");
        wr(2'd2, 32'h1F, "R2");
        rd(2'd2, "R8");
        smp(4'd0, 16'h0200, 1'b0, 1'b0, "R7");
        conv_enable = 1'b0;

        // random mixed traffic
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 50) == 0) conv_enable = ~conv_enable;
            res_valid  = ($urandom % 10) < 7;
            res_chan   = 4'($urandom);
            res_data   = 16'($urandom);
            res_signed = 1'($urandom);
            res_wide   = 1'($urandom);
            if (($urandom % 10) == 0) begin
                reg_wr = 1'b1;
                reg_addr = 2'($urandom);
                reg_wdata = $urandom;
            end
            step("R7");
            if ((i % 16) == 0) begin
                rd(2'd0, "R1"); rd(2'd1, "R9"); rd(2'd2, "R8");
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule